// File: doc/BRIEF.md
# DMA Burst Planner and Arbiter

This block stands between a transmit DMA channel, a receive DMA channel and one system-bus master port. When the bus is free it picks one requesting channel. It takes that channel's transfer (a word-aligned start address and a beat count) and issues it as a sequence of bus bursts. The burst type and length of each burst follow a set of mode bits: fixed-length bursts only, mixed undefined/fixed bursts, or plain undefined-length bursts. Every burst is capped by a programmable maximum length.

The bus can answer a burst with a normal completion. It can also report an interruption, caused by a retry, a split or a lost grant. In that case it states how many beats of the burst were moved. The block then reissues the beats still pending under a rebuild policy. One policy issues one continuous undefined-length run followed by a single last beat. The other policy issues fixed 16/8/4/1 bursts. When the owning channel's whole transfer has been moved, the block pulses a done flag to that channel.

Top module: `dma_burst_arbiter`

## Requirements
- R1: After reset `bus_valid`, `tx_done` and `rx_done` are low, and they stay low while no channel requests.
- R2: When both channels request in the same idle cycle, the receive channel wins if `cfg_tx_first` is 0 and the transmit channel wins if it is 1.
- R3: A granted channel keeps the bus until its whole transfer, rebuilt bursts included, has moved. Its done output then pulses high for exactly one cycle, with `bus_valid` low. Both done outputs are never high together.
- R4: The burst cap is `cfg_max_len`, with 0 treated as 1, multiplied by 8 when `cfg_len_x8` is 1.
- R5: With fixed and mixed modes both clear, each burst is type 1 (undefined length) with length min(remaining, cap). Its length is never 0.
- R6: With `cfg_fixed` set, each burst takes the largest size of 16, 8, 4 or 1 that is at or below both the remaining beats and the cap. The `bus_kind` codes are 0 single (length 1), 1 undefined length, 2 fixed 4, 3 fixed 8 and 4 fixed 16.
- R7: With `cfg_mixed` set and `cfg_fixed` clear, a burst for a remaining count above 16 is type 1 with length min(remaining, cap). Otherwise it is split as in R6.
- R8: After an interruption with `cfg_rebuild_fixed` at 0, the pending beats go out as type-1 bursts of min(pending-1, cap) while more than one beat is pending. The final beat then goes out as type 0. The address resumes at the old address plus 4 times `bus_moved`.
- R9: After an interruption with `cfg_rebuild_fixed` at 1, the pending beats are split as in R6.
- R10: While `bus_valid` is high and the bus gives no answer, the address, kind and length hold steady. After a normal completion, the next burst of the same transfer starts at the previous address plus 4 times its length.
- R11: The mode bits and the cap are sampled when a channel is granted. Changes made during the transfer do not affect its bursts.
- R12: A granted request of 0 beats issues no burst. Its done pulse appears one cycle after the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_fixed | input | 1 | Fixed-length bursts only |
| cfg_mixed | input | 1 | Mixed undefined/fixed bursts |
| cfg_rebuild_fixed | input | 1 | Rebuild policy: 1 = fixed split |
| cfg_tx_first | input | 1 | Transmit channel wins ties |
| cfg_max_len | input | 6 | Maximum burst length |
| cfg_len_x8 | input | 1 | Multiply max length by 8 |
| tx_req | input | 1 | Transmit request, held until done |
| tx_addr | input | ADDR_W | Transmit start address |
| tx_beats | input | BEAT_W | Transmit beat count |
| tx_done | output | 1 | Transmit transfer complete pulse |
| rx_req | input | 1 | Receive request, held until done |
| rx_addr | input | ADDR_W | Receive start address |
| rx_beats | input | BEAT_W | Receive beat count |
| rx_done | output | 1 | Receive transfer complete pulse |
| bus_valid | output | 1 | Burst presented to the bus |
| bus_addr | output | ADDR_W | Burst start address |
| bus_kind | output | 3 | Burst type code |
| bus_len | output | BEAT_W | Burst beat count |
| bus_ok | input | 1 | Burst completed |
| bus_retry | input | 1 | Burst interrupted |
| bus_moved | input | BEAT_W | Beats moved before interruption |

## Verification
A corrupted remaining count or address shows up at the ports on the very next burst. The presented kind, length or address then departs from the one the bench predicts from its own beat bookkeeping. Missing that, the done pulse arrives a burst early or late. A lost rebuild flag or a wrongly latched mode bit surfaces on the first burst after an interruption or a grant. An arbitration error shows up in the order in which the two done pulses appear.

// File: rtl/dma_burst_pkg.sv
`timescale 1ns/1ps
package dma_burst_pkg;

    localparam int MAXLEN_W = 6;

    typedef enum logic [2:0] {
        BT_SINGLE = 3'd0,
        BT_INCR   = 3'd1,
        BT_FIX4   = 3'd2,
        BT_FIX8   = 3'd3,
        BT_FIX16  = 3'd4
    } burst_kind_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } fsm_e;

    typedef struct packed {
        logic                fixed_en;
        logic                mixed_en;
        logic                rebuild_fixed;
        logic [MAXLEN_W-1:0] max_len;
        logic                len_x8;
    } mode_cfg_t;

endpackage

// File: rtl/dma_arb_select.sv
`timescale 1ns/1ps
module dma_arb_select (
    input  logic tx_req,
    input  logic rx_req,
    input  logic tx_first,
    output logic pick_tx,
    output logic any_req
);
    always_comb begin
        any_req = tx_req | rx_req;
        if (tx_req && rx_req) begin
            pick_tx = tx_first;
        end else begin
            pick_tx = tx_req;
        end
    end
endmodule

// File: rtl/dma_burst_planner.sv
`timescale 1ns/1ps
module dma_burst_planner
    import dma_burst_pkg::*;
#(
    parameter int BEAT_W = 12
) (
    input  logic [BEAT_W-1:0] rem,
    input  logic              rebuilding,
    input  mode_cfg_t         cfg,
    output burst_kind_e       kind,
    output logic [BEAT_W-1:0] len
);
    localparam int CAP_W = MAXLEN_W + 3;
    localparam int CMP_W = (BEAT_W > CAP_W) ? BEAT_W : CAP_W;

    logic [CMP_W-1:0] base_len;
    logic [CMP_W-1:0] cap;
    logic [CMP_W-1:0] rem_w;
    logic [CMP_W-1:0] lim;
    logic [CMP_W-1:0] rb_lim;
    burst_kind_e      fix_kind;
    logic [CMP_W-1:0] fix_len;

    // cap and limits
    always_comb begin
        base_len = (cfg.max_len == '0) ? CMP_W'(1) : CMP_W'(cfg.max_len);
        cap      = cfg.len_x8 ? (base_len << 3) : base_len;
        rem_w    = CMP_W'(rem);
        lim      = (rem_w < cap) ? rem_w : cap;
        rb_lim   = ((rem_w - CMP_W'(1)) < cap) ? (rem_w - CMP_W'(1)) : cap;
    end

    // largest fixed size not above lim
    always_comb begin
        if (lim >= CMP_W'(16)) begin
            fix_kind = BT_FIX16;
            fix_len  = CMP_W'(16);
        end else if (lim >= CMP_W'(8)) begin
            fix_kind = BT_FIX8;
            fix_len  = CMP_W'(8);
        end else if (lim >= CMP_W'(4)) begin
            fix_kind = BT_FIX4;
            fix_len  = CMP_W'(4);
        end else begin
            fix_kind = BT_SINGLE;
            fix_len  = CMP_W'(1);
        end
    end

    // policy selection
    always_comb begin
        kind = BT_INCR;
        len  = BEAT_W'(lim);
        if (rebuilding) begin
            if (cfg.rebuild_fixed) begin
                kind = fix_kind;
                len  = BEAT_W'(fix_len);
            end else if (rem_w <= CMP_W'(1)) begin
                kind = BT_SINGLE;
                len  = BEAT_W'(1);
            end else begin
                kind = BT_INCR;
                len  = BEAT_W'(rb_lim);
            end
        end else if (cfg.fixed_en) begin
            kind = fix_kind;
            len  = BEAT_W'(fix_len);
        end else if (cfg.mixed_en && rem_w <= CMP_W'(16)) begin
            kind = fix_kind;
            len  = BEAT_W'(fix_len);
        end else if (lim == '0) begin
            kind = BT_INCR;
            len  = BEAT_W'(1);
        end
    end
endmodule

// File: rtl/dma_burst_arbiter.sv
`timescale 1ns/1ps
module dma_burst_arbiter
    import dma_burst_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int BEAT_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_fixed,
    input  logic                cfg_mixed,
    input  logic                cfg_rebuild_fixed,
    input  logic                cfg_tx_first,
    input  logic [MAXLEN_W-1:0] cfg_max_len,
    input  logic                cfg_len_x8,
    input  logic                tx_req,
    input  logic [ADDR_W-1:0]   tx_addr,
    input  logic [BEAT_W-1:0]   tx_beats,
    output logic                tx_done,
    input  logic                rx_req,
    input  logic [ADDR_W-1:0]   rx_addr,
    input  logic [BEAT_W-1:0]   rx_beats,
    output logic                rx_done,
    output logic                bus_valid,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic [2:0]          bus_kind,
    output logic [BEAT_W-1:0]   bus_len,
    input  logic                bus_ok,
    input  logic                bus_retry,
    input  logic [BEAT_W-1:0]   bus_moved
);
    typedef struct packed {
        fsm_e              fsm;
        logic              owner_tx;
        logic [ADDR_W-1:0] addr;
        logic [BEAT_W-1:0] rem;
        logic              rebuilding;
        mode_cfg_t         cfg;
        logic              done_tx;
        logic              done_rx;
    } state_t;

    state_t st_d, st_q;

    logic              pick_tx;
    logic              any_req;
    burst_kind_e       plan_kind;
    logic [BEAT_W-1:0] plan_len;
    logic [BEAT_W-1:0] moved;
    logic [BEAT_W-1:0] rem_after;
    logic [ADDR_W-1:0] addr_after;
    logic [BEAT_W-1:0] grant_beats;
    logic [ADDR_W-1:0] grant_addr;

    dma_arb_select u_sel (
        .tx_req   (tx_req),
        .rx_req   (rx_req),
        .tx_first (cfg_tx_first),
        .pick_tx  (pick_tx),
        .any_req  (any_req)
    );

    dma_burst_planner #(.BEAT_W(BEAT_W)) u_plan (
        .rem        (st_q.rem),
        .rebuilding (st_q.rebuilding),
        .cfg        (st_q.cfg),
        .kind       (plan_kind),
        .len        (plan_len)
    );

    // beats moved by the current answer
    always_comb begin
        if (bus_retry && !bus_ok) begin
            moved = (bus_moved < plan_len) ? bus_moved : plan_len;
        end else begin
            moved = plan_len;
        end
        rem_after   = st_q.rem - moved;
        addr_after  = st_q.addr + (ADDR_W'(moved) << 2);
        grant_beats = pick_tx ? tx_beats : rx_beats;
        grant_addr  = pick_tx ? tx_addr : rx_addr;
    end

    always_comb begin
        st_d         = st_q;
        st_d.done_tx = 1'b0;
        st_d.done_rx = 1'b0;
        case (st_q.fsm)
            ST_IDLE: begin
                if (any_req) begin
                    st_d.owner_tx          = pick_tx;
                    st_d.addr              = grant_addr;
                    st_d.rem               = grant_beats;
                    st_d.rebuilding        = 1'b0;
                    st_d.cfg.fixed_en      = cfg_fixed;
                    st_d.cfg.mixed_en      = cfg_mixed;
                    st_d.cfg.rebuild_fixed = cfg_rebuild_fixed;
                    st_d.cfg.max_len       = cfg_max_len;
                    st_d.cfg.len_x8        = cfg_len_x8;
                    if (grant_beats == '0) begin
                        st_d.done_tx = pick_tx;
                        st_d.done_rx = !pick_tx;
                    end else begin
                        st_d.fsm = ST_ISSUE;
                    end
                end
            end
            ST_ISSUE: begin
                if (bus_ok || bus_retry) begin
                    st_d.rem  = rem_after;
                    st_d.addr = addr_after;
                    if (!bus_ok) begin
                        st_d.rebuilding = 1'b1;
                    end
                    if (rem_after == '0) begin
                        st_d.fsm     = ST_IDLE;
                        st_d.done_tx = st_q.owner_tx;
                        st_d.done_rx = !st_q.owner_tx;
                    end
                end
            end
            default: st_d.fsm = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_valid = (st_q.fsm == ST_ISSUE);
        bus_addr  = st_q.addr;
        bus_kind  = plan_kind;
        bus_len   = plan_len;
        tx_done   = st_q.done_tx;
        rx_done   = st_q.done_rx;
    end
endmodule

// File: rtl/dma_burst_arbiter_chk.sv
`timescale 1ns/1ps
module dma_burst_arbiter_chk #(
    parameter int ADDR_W = 32,
    parameter int BEAT_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_ok,
    input logic              bus_retry,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [2:0]        bus_kind,
    input logic [BEAT_W-1:0] bus_len,
    input logic              tx_done,
    input logic              rx_done
);
    assert_done_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tx_done, rx_done}));

    assert_done_bus_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done || rx_done) |-> !bus_valid);

    assert_len_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> (bus_len != '0));

    assert_single_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_kind == 3'd0) |-> (bus_len == BEAT_W'(1)));

    assert_fix4_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_kind == 3'd2) |-> (bus_len == BEAT_W'(4)));

    assert_fix8_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_kind == 3'd3) |-> (bus_len == BEAT_W'(8)));

    assert_fix16_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_kind == 3'd4) |-> (bus_len == BEAT_W'(16)));

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ok && !bus_retry) |=>
            (bus_valid && $stable(bus_addr) && $stable(bus_kind) && $stable(bus_len)));

    assert_addr_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_ok) |=>
            (!bus_valid || bus_addr == $past(bus_addr) + (ADDR_W'($past(bus_len)) << 2)));
endmodule

bind dma_burst_arbiter dma_burst_arbiter_chk #(
    .ADDR_W (ADDR_W),
    .BEAT_W (BEAT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_ok    (bus_ok),
    .bus_retry (bus_retry),
    .bus_addr  (bus_addr),
    .bus_kind  (bus_kind),
    .bus_len   (bus_len),
    .tx_done   (tx_done),
    .rx_done   (rx_done)
);

// File: tb/dma_burst_arbiter_tb.sv
`timescale 1ns/1ps
module dma_burst_arbiter_tb;
    localparam int ADDR_W = 32;
    localparam int BEAT_W = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_fixed = 0, cfg_mixed = 0, cfg_rebuild_fixed = 0, cfg_tx_first = 0;
    logic [5:0]        cfg_max_len = 6'd0;
    logic              cfg_len_x8 = 0;
    logic              tx_req = 0, rx_req = 0;
    logic [ADDR_W-1:0] tx_addr = '0, rx_addr = '0;
    logic [BEAT_W-1:0] tx_beats = '0, rx_beats = '0;
    logic              tx_done, rx_done;
    logic              bus_valid;
    logic [ADDR_W-1:0] bus_addr;
    logic [2:0]        bus_kind;
    logic [BEAT_W-1:0] bus_len;
    logic              bus_ok = 0, bus_retry = 0;
    logic [BEAT_W-1:0] bus_moved = '0;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    dma_burst_arbiter #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_fixed(cfg_fixed), .cfg_mixed(cfg_mixed), .cfg_rebuild_fixed(cfg_rebuild_fixed),
        .cfg_tx_first(cfg_tx_first), .cfg_max_len(cfg_max_len), .cfg_len_x8(cfg_len_x8),
        .tx_req(tx_req), .tx_addr(tx_addr), .tx_beats(tx_beats), .tx_done(tx_done),
        .rx_req(rx_req), .rx_addr(rx_addr), .rx_beats(rx_beats), .rx_done(rx_done),
        .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_kind(bus_kind), .bus_len(bus_len),
        .bus_ok(bus_ok), .bus_retry(bus_retry), .bus_moved(bus_moved)
    );

    task automatic chk(input bit good, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!good) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int cap_of(input int ml, input bit x8);
        int c;
        c = (ml == 0) ? 1 : ml;
        return x8 ? c * 8 : c;
    endfunction

    function automatic void fix_split(input int lim, output int kind, output int len);
        if (lim >= 16) begin kind = 4; len = 16; end
        else if (lim >= 8) begin kind = 3; len = 8; end
        else if (lim >= 4) begin kind = 2; len = 4; end
        else begin kind = 0; len = 1; end
    endfunction

    function automatic void plan(input int rem, input int cap, input bit fx, input bit mx,
                                 input bit rbf, input bit rebuilding,
                                 output int kind, output int len);
        int lim;
        lim = (rem < cap) ? rem : cap;
        if (rebuilding) begin
            if (rbf) fix_split(lim, kind, len);
            else if (rem <= 1) begin kind = 0; len = 1; end
            else begin kind = 1; len = ((rem - 1) < cap) ? rem - 1 : cap; end
        end else if (fx || (mx && rem <= 16)) begin
            fix_split(lim, kind, len);
        end else begin
            kind = 1; len = lim;
        end
    endfunction

    task automatic set_cfg(input bit fx, input bit mx, input bit rbf, input bit txf,
                           input int ml, input bit x8);
        cfg_fixed = fx; cfg_mixed = mx; cfg_rebuild_fixed = rbf;
        cfg_tx_first = txf; cfg_max_len = 6'(ml); cfg_len_x8 = x8;
    endtask

    task automatic raise(input bit is_tx, input int addr, input int beats);
        if (is_tx) begin tx_req = 1; tx_addr = ADDR_W'(addr); tx_beats = BEAT_W'(beats); end
        else       begin rx_req = 1; rx_addr = ADDR_W'(addr); rx_beats = BEAT_W'(beats); end
    endtask

    // services one granted request and checks every burst against the model
    task automatic serve(input bit is_tx, input string tag, input bit allow_retry,
                         input int force_moved, input bit scramble);
        int rem, cap, ek, el, retries, mv;
        bit fx, mx, rbf, rb, stall;
        logic [ADDR_W-1:0] addr;
        string t;
        rem  = is_tx ? int'(tx_beats) : int'(rx_beats);
        addr = is_tx ? tx_addr : rx_addr;
        fx = cfg_fixed; mx = cfg_mixed; rbf = cfg_rebuild_fixed;
        cap = cap_of(int'(cfg_max_len), cfg_len_x8);
        rb = 0; retries = 0;
        for (int w = 0; w < 4; w++) begin
            @(negedge clk);
            if (bus_valid) break;
        end
        if (scramble) set_cfg($urandom % 2, $urandom % 2, $urandom % 2, cfg_tx_first,
                              $urandom % 64, $urandom % 2);
        for (int guard = 0; guard < 400; guard++) begin
            plan(rem, cap, fx, mx, rbf, rb, ek, el);
            if (tag != "") t = tag;
            else if (rb) t = rbf ? "R9" : "R8";
            else if (fx) t = "R6";
            else if (mx) t = "R7";
            else t = "R5";
            chk(bus_valid && int'(bus_kind) == ek && int'(bus_len) == el && bus_addr == addr,
                t, "burst kind*65536+len",
                longint'(bus_valid) * 1000000 + longint'(bus_kind) * 65536 + longint'(bus_len),
                1000000 + longint'(ek) * 65536 + el);
            if (!bus_valid) break;
            chk(bus_addr == addr, t, "burst address", bus_addr, addr);
            stall = ($urandom % 4) == 0;
            if (stall) begin
                @(negedge clk);
                chk(bus_valid && int'(bus_kind) == ek && int'(bus_len) == el && bus_addr == addr,
                    "R10", "held burst len", bus_len, el);
            end
            mv = el;
            if (force_moved >= 0 && retries == 0) begin
                mv = force_moved; bus_retry = 1; bus_moved = BEAT_W'(mv); retries++;
            end else if (allow_retry && retries < 3 && ($urandom % 4) == 0) begin
                mv = $urandom % el; bus_retry = 1; bus_moved = BEAT_W'(mv); retries++;
            end else begin
                bus_ok = 1;
            end
            @(negedge clk);
            if (bus_retry) rb = 1;
            bus_ok = 0; bus_retry = 0; bus_moved = '0;
            rem  = rem - mv;
            addr = addr + ADDR_W'(mv * 4);
            if (rem == 0) begin
                chk((is_tx ? tx_done : rx_done) && !(is_tx ? rx_done : tx_done) && !bus_valid,
                    "R3", "done pulse", {tx_done, rx_done, bus_valid}, is_tx ? 3'b100 : 3'b010);
                if (is_tx) tx_req = 0; else rx_req = 0;
                @(negedge clk);
                chk(!tx_done && !rx_done, "R3", "done one cycle", {tx_done, rx_done}, 0);
                break;
            end
        end
    endtask

    initial begin
        #(8 * 150000);
        total++; bad++;
        $display("FAIL watchdog R3 actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(!bus_valid && !tx_done && !rx_done, "R1", "idle outputs",
                {bus_valid, tx_done, rx_done}, 0);
        end

        // cap: 0 means 1
        set_cfg(0, 0, 0, 0, 0, 0);
        raise(1, 32'h100, 3);
        serve(1, "R4", 0, -1, 0);
        // cap times eight
        set_cfg(0, 0, 0, 0, 2, 1);
        raise(0, 32'h2000, 20);
        serve(0, "R4", 0, -1, 0);
        // plain undefined bursts
        set_cfg(0, 0, 0, 0, 7, 0);
        raise(1, 32'h400, 17);
        serve(1, "R5", 0, -1, 0);
        // fixed split 16,8,4,1
        set_cfg(1, 0, 0, 0, 63, 0);
        raise(0, 32'h800, 29);
        serve(0, "R6", 0, -1, 0);
        // mixed: 10,10 undefined then fixed 8,1,1
        set_cfg(0, 1, 0, 0, 10, 0);
        raise(1, 32'h1000, 30);
        serve(1, "R7", 0, -1, 0);
        // rebuild as undefined run plus single
        set_cfg(0, 0, 0, 0, 63, 0);
        raise(0, 32'h3000, 10);
        serve(0, "R8", 0, 3, 0);
        // rebuild as fixed split
        set_cfg(1, 0, 1, 0, 63, 0);
        raise(1, 32'h5000, 16);
        serve(1, "R9", 0, 5, 0);
        // config changes after grant are ignored
        set_cfg(1, 0, 0, 0, 4, 0);
        raise(0, 32'h6000, 23);
        serve(0, "R11", 0, -1, 1);
        // zero beats
        set_cfg(0, 0, 0, 0, 8, 0);
        raise(1, 32'h7000, 0);
        @(negedge clk);
        chk(tx_done && !rx_done && !bus_valid, "R12", "zero-beat done",
            {tx_done, rx_done, bus_valid}, 3'b100);
        tx_req = 0;
        @(negedge clk);
        chk(!tx_done && !bus_valid, "R12", "no burst after zero-beat", {tx_done, bus_valid}, 0);

        // tie breaks both ways
        for (int p = 0; p < 2; p++) begin
            set_cfg(0, 0, 0, p[0], 8, 0);
            raise(1, 32'h9000, 12);
            raise(0, 32'hA000, 9);
            @(negedge clk);
            chk(bus_valid && bus_addr == (p ? 32'h9000 : 32'hA000), "R2", "tie winner addr",
                bus_addr, p ? 32'h9000 : 32'hA000);
            tx_req = tx_req; // winner continues below
            serve(p[0], "", 0, -1, 0);
            serve(!p[0], "", 0, -1, 0);
        end

        // constrained random mix
        void'($urandom(32'h5eed1234));
        for (int n = 0; n < 120; n++) begin
            set_cfg($urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2,
                    $urandom % 64, ($urandom % 4) == 0);
            if (($urandom % 3) == 0) begin
                raise(1, ($urandom % 4096) * 4, 1 + $urandom % 70);
                raise(0, ($urandom % 4096) * 4, 1 + $urandom % 70);
                serve(cfg_tx_first, "", 1, -1, 0);
                serve(!cfg_tx_first, "", 1, -1, 0);
            end else begin
                raise(n[0], ($urandom % 4096) * 4, 1 + $urandom % 90);
                serve(n[0], "", 1, -1, 0);
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule